// File: doc/BRIEF.md
# Streamed-Load Color Lookup Table

This block holds the color lookup table that sits between a pixel stream and a digital-to-analog stage. Each of its entries holds three 6-bit color components: red, green and blue. Software first writes a starting entry number to a load-pointer strobe. It then sends the components one byte at a time through a single shared data strobe, in the order red, green, blue. When the blue byte of an entry has been written, the pointer moves to the next entry on its own. A whole block of consecutive entries can therefore be loaded with one pointer write followed by an unbroken run of data writes.

A second pointer, the fetch pointer, reads the table back through the same component sequence. Reading advances it in the same way. A pixel mask register is ANDed with every incoming pixel index before the lookup, which lets software restrict the pixel path to a subset of the table. The looked-up color is registered, so it appears one clock after the pixel index is presented.

Top module: `clut_port`

## Requirements
- R1: After synchronous reset, both pointers are at entry 0 in the red phase, the mask is 0xFF, every table component is 0, `rgb_out` is 0 and `bus_rdata` is 0.
- R2: A `wr_idx_we` strobe loads the load pointer from `bus_wdata` and returns its component phase to red. This holds even part-way through an entry; components already written to the old entry stay as they are.
- R3: Successive `data_we` strobes store into the red, then green, then blue component of the entry the load pointer selects. Only `bus_wdata[5:0]` is stored. `rgb_out` packs red in bits [17:12], green in [11:6] and blue in [5:0].
- R4: After the blue component is stored, the load pointer advances by one and the phase returns to red. Entry 255 is followed by entry 0.
- R5: `rgb_out` equals the table entry at (`pix_idx` AND mask), as held at the previous rising clock edge, one cycle after `pix_idx` is sampled. A table write in the same cycle as the lookup does not show in that lookup.
- R6: A `mask_we` strobe loads the mask from `bus_wdata`. The mask keeps its value otherwise, and a mask of 0xFF passes the pixel index through unchanged.
- R7: A `rd_idx_we` strobe loads the fetch pointer and sets its phase to red. `bus_rdata` always shows, zero-extended, the component of the fetch entry selected by the fetch phase. Each `data_re` strobe steps red, green, blue, and after blue the fetch pointer advances, wrapping from 255 to 0.
- R8: When `wr_idx_we` and `data_we` are asserted in the same cycle, the pointer load wins and the data byte is discarded. The same rule applies to `rd_idx_we` against `data_re`.
- R9: One pointer write followed by 192 consecutive data writes loads 64 consecutive entries completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_idx_we | input | 1 | Load the load pointer from bus_wdata |
| rd_idx_we | input | 1 | Load the fetch pointer from bus_wdata |
| data_we | input | 1 | Store one component byte at the load pointer |
| data_re | input | 1 | Consume one component at the fetch pointer |
| mask_we | input | 1 | Load the pixel mask from bus_wdata |
| bus_wdata | input | 8 | Write data for all strobes |
| bus_rdata | output | 8 | Current fetch component, zero-extended |
| pix_idx | input | 8 | Pixel index to look up |
| rgb_out | output | 18 | Registered color {red, green, blue} |

## Verification
The load path is tried three ways, each against a bench model of the table. One is a full 192-byte burst whose bytes have random upper bits, which checks that only the low 6 bits are stored and that the pointer advances after each triple. Another is a run that crosses entry 255, which checks the wrap. The third reloads the pointer part-way through an entry, including in the same cycle as a data strobe, which separates a phase reset from a lost or misplaced byte. The pixel path is checked with the full mask and with a narrow mask, which shows whether masking is applied at all. A long random mix of writes, pointer loads, readbacks and lookups then checks that lookup, load and fetch never disturb each other.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Which color component the next data access touches
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } comp_ph_t;

    localparam int N_COMP = 3;

    function automatic comp_ph_t next_ph(input comp_ph_t ph);
        case (ph)
            PH_RED:  return PH_GRN;
            PH_GRN:  return PH_BLU;
            default: return PH_RED;
        endcase
    endfunction

endpackage

// File: rtl/clut_seq.sv
// Entry pointer plus component phase; a load beats a step
module clut_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] ptr,
    output comp_ph_t         ph
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            ph  <= PH_RED;
        end else if (load) begin
            ptr <= load_val;
            ph  <= PH_RED;
        end else if (step) begin
            ph <= next_ph(ph);
            if (ph == PH_BLU) begin
                ptr <= ptr + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clut_store.sv
// One storage array per component; registered pixel port, combinational fetch port
module clut_store
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  comp_ph_t                 w_ph,
    input  logic [IDX_W-1:0]         w_idx,
    input  logic [COMP_W-1:0]        w_val,
    input  logic [IDX_W-1:0]         pix_addr,
    output logic [N_COMP*COMP_W-1:0] pix_rgb,
    input  logic [IDX_W-1:0]         fb_idx,
    input  comp_ph_t                 fb_ph,
    output logic [COMP_W-1:0]        fb_val
);

    localparam int DEPTH = 1 << IDX_W;

    logic [COMP_W-1:0] fb_c [N_COMP];

    for (genvar c = 0; c < N_COMP; c++) begin : g_comp
        logic [COMP_W-1:0] mem [DEPTH];
        logic [COMP_W-1:0] pix_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) begin
                    mem[i] <= '0;
                end
                pix_q <= '0;
            end else begin
                if (we && (w_ph == comp_ph_t'(c))) begin
                    mem[w_idx] <= w_val;
                end
                pix_q <= mem[pix_addr];
            end
        end

        // red occupies the top field
        assign pix_rgb[(N_COMP-1-c)*COMP_W +: COMP_W] = pix_q;
        assign fb_c[c] = mem[fb_idx];
    end

    always_comb begin
        case (fb_ph)
            PH_RED:  fb_val = fb_c[0];
            PH_GRN:  fb_val = fb_c[1];
            PH_BLU:  fb_val = fb_c[2];
            default: fb_val = '0;
        endcase
    end

endmodule

// File: rtl/clut_port.sv
module clut_port
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int BUS_W  = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_idx_we,
    input  logic                     rd_idx_we,
    input  logic                     data_we,
    input  logic                     data_re,
    input  logic                     mask_we,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata,
    input  logic [IDX_W-1:0]         pix_idx,
    output logic [N_COMP*COMP_W-1:0] rgb_out
);

    localparam int PAD_W = BUS_W - COMP_W;

    logic [IDX_W-1:0]  wr_ptr;
    logic [IDX_W-1:0]  rd_ptr;
    logic [IDX_W-1:0]  mask_q;
    logic [IDX_W-1:0]  lut_addr;
    comp_ph_t          wr_ph;
    comp_ph_t          rd_ph;
    logic              wr_step;
    logic              rd_step;
    logic [COMP_W-1:0] fb_val;

    // a pointer load in the same cycle discards the data access
    assign wr_step = data_we & ~wr_idx_we;
    assign rd_step = data_re & ~rd_idx_we;

    clut_seq #(.IDX_W(IDX_W)) u_wseq (
        .clk      (clk),
        .rst      (rst),
        .load     (wr_idx_we),
        .load_val (bus_wdata[IDX_W-1:0]),
        .step     (wr_step),
        .ptr      (wr_ptr),
        .ph       (wr_ph)
    );

    clut_seq #(.IDX_W(IDX_W)) u_rseq (
        .clk      (clk),
        .rst      (rst),
        .load     (rd_idx_we),
        .load_val (bus_wdata[IDX_W-1:0]),
        .step     (rd_step),
        .ptr      (rd_ptr),
        .ph       (rd_ph)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
        end else if (mask_we) begin
            mask_q <= bus_wdata[IDX_W-1:0];
        end
    end

    assign lut_addr = pix_idx & mask_q;

    clut_store #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_step),
        .w_ph     (wr_ph),
        .w_idx    (wr_ptr),
        .w_val    (bus_wdata[COMP_W-1:0]),
        .pix_addr (lut_addr),
        .pix_rgb  (rgb_out),
        .fb_idx   (rd_ptr),
        .fb_ph    (rd_ph),
        .fb_val   (fb_val)
    );

    assign bus_rdata = {{PAD_W{1'b0}}, fb_val};

endmodule

// File: rtl/clut_port_chk.sv
module clut_port_chk
    import clut_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int COMP_W = 6,
    parameter int BUS_W  = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     wr_idx_we,
    input logic                     rd_idx_we,
    input logic                     data_we,
    input logic                     data_re,
    input logic                     mask_we,
    input logic [BUS_W-1:0]         bus_wdata,
    input logic [IDX_W-1:0]         pix_idx,
    input logic [N_COMP*COMP_W-1:0] rgb_out,
    input logic [IDX_W-1:0]         wr_ptr,
    input logic [IDX_W-1:0]         rd_ptr,
    input logic [IDX_W-1:0]         mask_q,
    input comp_ph_t                 wr_ph,
    input comp_ph_t                 rd_ph
);

    a_r1_reset_state: assert property (@(posedge clk)
        $fell(rst) |-> (wr_ptr == '0 && rd_ptr == '0 && mask_q == '1 &&
                        rgb_out == '0 && wr_ph == PH_RED && rd_ph == PH_RED));

    a_r2_index_load: assert property (@(posedge clk) disable iff (rst)
        wr_idx_we |=> (wr_ptr == $past(bus_wdata[IDX_W-1:0]) && wr_ph == PH_RED));

    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
        (data_we && !wr_idx_we && wr_ph != PH_BLU)
            |=> ($stable(wr_ptr) && wr_ph != $past(wr_ph)));

    a_r4_entry_advance: assert property (@(posedge clk) disable iff (rst)
        (data_we && !wr_idx_we && wr_ph == PH_BLU)
            |=> (wr_ptr == IDX_W'($past(wr_ptr) + 1'b1) && wr_ph == PH_RED));

    a_r5_out_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(data_we) && !$past(mask_we) && $stable(pix_idx) && !data_we && !mask_we)
            |=> $stable(rgb_out));

    a_r6_mask_hold: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q));

    a_r7_fetch_advance: assert property (@(posedge clk) disable iff (rst)
        (data_re && !rd_idx_we && rd_ph == PH_BLU)
            |=> (rd_ptr == IDX_W'($past(rd_ptr) + 1'b1) && rd_ph == PH_RED));

    a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_we && data_re) |=> (rd_ptr == $past(bus_wdata[IDX_W-1:0]) && rd_ph == PH_RED));

endmodule

bind clut_port clut_port_chk #(.IDX_W(IDX_W), .COMP_W(COMP_W), .BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_idx_we (wr_idx_we),
    .rd_idx_we (rd_idx_we),
    .data_we   (data_we),
    .data_re   (data_re),
    .mask_we   (mask_we),
    .bus_wdata (bus_wdata),
    .pix_idx   (pix_idx),
    .rgb_out   (rgb_out),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr),
    .mask_q    (mask_q),
    .wr_ph     (wr_ph),
    .rd_ph     (rd_ph)
);

// File: tb/sim_clut_port.sv
module sim_clut_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_idx_we = 1'b0;
    logic        rd_idx_we = 1'b0;
    logic        data_we = 1'b0;
    logic        data_re = 1'b0;
    logic        mask_we = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic [7:0]  pix_idx = 8'h00;
    logic [17:0] rgb_out;

    always #10 clk = ~clk;

    clut_port u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_idx_we (wr_idx_we),
        .rd_idx_we (rd_idx_we),
        .data_we   (data_we),
        .data_re   (data_re),
        .mask_we   (mask_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pix_idx   (pix_idx),
        .rgb_out   (rgb_out)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model
    logic [17:0] tbl [256];
    logic [7:0]  m_mask = 8'hFF;
    logic [7:0]  m_wp = 8'h00;
    logic [7:0]  m_rp = 8'h00;
    int          m_wph = 0;
    int          m_rph = 0;

    function automatic logic [17:0] exp_pix(input logic [7:0] p);
        return tbl[p & m_mask];
    endfunction

    function automatic logic [5:0] comp_of(input logic [17:0] e, input int ph);
        case (ph)
            0:       return e[17:12];
            1:       return e[11:6];
            default: return e[5:0];
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_widx(input logic [7:0] v);
        bus_wdata = v;
        wr_idx_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_idx_we = 1'b0;
        m_wp  = v;
        m_wph = 0;
    endtask

    task automatic do_wdata(input logic [7:0] v);
        bus_wdata = v;
        data_we   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        data_we = 1'b0;
        case (m_wph)
            0:       tbl[m_wp][17:12] = v[5:0];
            1:       tbl[m_wp][11:6]  = v[5:0];
            default: tbl[m_wp][5:0]   = v[5:0];
        endcase
        if (m_wph == 2) begin
            m_wph = 0;
            m_wp  = m_wp + 8'd1;
        end else begin
            m_wph++;
        end
    endtask

    task automatic do_mask(input logic [7:0] v);
        bus_wdata = v;
        mask_we   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mask_we = 1'b0;
        m_mask  = v;
    endtask

    task automatic do_ridx(input logic [7:0] v);
        bus_wdata = v;
        rd_idx_we = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_idx_we = 1'b0;
        m_rp  = v;
        m_rph = 0;
    endtask

    task automatic do_read(input string req);
        check(req, {24'h0, bus_rdata}, {26'h0, comp_of(tbl[m_rp], m_rph)});
        data_re = 1'b1;
        @(posedge clk);
        @(negedge clk);
        data_re = 1'b0;
        if (m_rph == 2) begin
            m_rph = 0;
            m_rp  = m_rp + 8'd1;
        end else begin
            m_rph++;
        end
    endtask

    task automatic look(input logic [7:0] p, input string req);
        pix_idx = p;
        @(posedge clk);
        @(negedge clk);
        check(req, {14'h0, rgb_out}, {14'h0, exp_pix(p)});
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] old_wp;
        void'($urandom(32'd2718));
        for (int i = 0; i < 256; i++) tbl[i] = 18'h0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 rgb", {14'h0, rgb_out}, 32'h0);
        check("R1 rdata", {24'h0, bus_rdata}, 32'h0);
        look(8'hFF, "R1 lookup");

        // R9: one pointer write, 192 data bytes, upper bits random
        do_widx(8'h00);
        for (int i = 0; i < 192; i++) do_wdata(8'($urandom));
        for (int i = 0; i < 64; i++) look(8'(i), "R9 burst entry");
        // R7: read back the burst
        do_ridx(8'h00);
        for (int i = 0; i < 192; i++) do_read("R7 readback");

        // R3: component order and 6-bit storage, fixed value
        do_widx(8'h05);
        do_wdata(8'hC1);
        do_wdata(8'h7F);
        do_wdata(8'h80);
        look(8'h05, "R3 order");
        check("R3 packed", {14'h0, rgb_out}, {14'h0, 6'h01, 6'h3F, 6'h00});

        // R4: wrap from 255 to 0
        do_widx(8'hFF);
        for (int i = 0; i < 7; i++) do_wdata(8'($urandom));
        look(8'hFF, "R4 last entry");
        look(8'h00, "R4 wrapped entry");
        look(8'h01, "R4 after wrap");

        // R2: pointer reload mid-entry
        do_widx(8'h0A);
        do_wdata(8'h11);
        do_widx(8'h14);
        do_wdata(8'h21);
        do_wdata(8'h22);
        do_wdata(8'h23);
        look(8'h0A, "R2 partial entry");
        look(8'h14, "R2 new entry");

        // R8: pointer load and data strobe together
        do_widx(8'h40);
        do_wdata(8'h01);
        old_wp = m_wp;
        bus_wdata = 8'h1E;
        wr_idx_we = 1'b1;
        data_we   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_idx_we = 1'b0;
        data_we   = 1'b0;
        m_wp  = 8'h1E;
        m_wph = 0;
        look(old_wp, "R8 old entry untouched");
        do_wdata(8'h2A);
        do_wdata(8'h15);
        do_wdata(8'h3F);
        look(8'h1E, "R8 loaded entry");

        // R6: default mask passes all bits, then a narrow mask
        do_widx(8'hF3);
        do_wdata(8'h33);
        do_wdata(8'h0C);
        do_wdata(8'h2D);
        look(8'hF3, "R6 full mask");
        do_mask(8'h0F);
        look(8'hF3, "R6 narrow mask");
        check("R6 narrow value", {14'h0, rgb_out}, {14'h0, tbl[8'h03]});
        do_mask(8'hFF);
        look(8'hF3, "R6 mask restored");

        // R7: fetch wrap and fetch pointer reload
        do_ridx(8'hFE);
        for (int i = 0; i < 9; i++) do_read("R7 fetch wrap");
        do_ridx(8'h14);
        do_read("R7 reload first");
        do_ridx(8'h14);
        do_read("R7 reload restarts red");

        // R5: random mix of lookups, writes, pointer loads and reads
        for (int i = 0; i < 400; i++) begin
            case ($urandom % 6)
                0, 1:    do_wdata(8'($urandom));
                2:       look(8'($urandom), "R5 random lookup");
                3:       do_widx(8'($urandom));
                4:       do_read("R7 random fetch");
                default: begin
                    if (($urandom % 4) == 0) do_ridx(8'($urandom));
                    else look(8'($urandom), "R5 random lookup");
                end
            endcase
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule